// File: doc/BRIEF.md
# Addressed Output Register Bank with Plotter Handshake

This block sits between a host that issues 16-bit command words and the output side of a data acquisition front end. Each command arrives on a valid/ready strobe. The top bit of the word decides where the command goes. A set bit passes a channel selection on to the input (conversion) subsystem as a one-cycle command pulse. A clear bit writes the low twelve bits into one of the addressed output registers. Two of these registers drive the X and Y DAC data lines, and one is a general digital output (Z) word. The remaining addresses are reserved.

The host supplies DAC values in two's complement. The DACs take inverted offset binary, so the block recodes the value as it stores it. The Z register keeps the host bits unchanged. A pen plotter is told to seek a new point only after a Y value has landed, so an X written on its own never causes a plot. Two asynchronous inputs are synchronised, edge-detected and stretched into fixed-length host flag pulses. One input is the plotter's plot-complete line and the other is a general external flag.

The command port never applies back-pressure. `cmd_ready` is held high, so every cycle with `cmd_valid` high is one accepted command.

Top module: `outreg_bank`

## Requirements
- R1: An accepted command with bit 15 = 1 produces `in_cmd_valid` high for exactly one cycle, in the cycle after acceptance, with `in_cmd_chan` equal to bits 14:12. No output register changes.
- R2: An accepted command with bit 15 = 0 and bits 14:12 = 0 loads the X DAC register with bits 11:0 XOR 12'h7FF, visible from the cycle after acceptance. Examples: 0x7FF becomes 0x000, 0x800 becomes 0xFFF, and 0xFFF becomes 0x800.
- R3: Address 1 loads the Y DAC register with the same recoding as R2.
- R4: Address 2 loads the Z register with bits 11:0 unchanged.
- R5: `plot_seek` pulses high for one cycle, two cycles after a Y write is accepted. No other command produces it.
- R6: A write to an address from 3 to 7 leaves every register unchanged and produces neither `plot_seek` nor `in_cmd_valid`.
- R7: A cycle with `cmd_valid` low changes no register and produces no pulse.
- R8: After reset, both DAC registers read 12'h7FF (mid-scale) and Z reads 0. All pulse outputs are low.
- R9: A rising edge on `plot_done_async` yields `host_flag_plot` high for exactly FLAG_CYCLES (default 4) consecutive cycles.
- R10: A rising edge on `ext_flag_async` yields `host_flag_ext` high for exactly FLAG_CYCLES consecutive cycles. A steady high level gives no further pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Always high; the block takes one command each cycle |
| cmd_word | input | 16 | Bit 15 selects direction, bits 14:12 are the address, bits 11:0 are the data |
| in_cmd_valid | output | 1 | One-cycle pulse for an input-subsystem command |
| in_cmd_chan | output | 3 | Channel of the last input command |
| dac_x | output | 12 | X DAC register, inverted offset binary |
| dac_y | output | 12 | Y DAC register, inverted offset binary |
| z_out | output | 12 | Digital output register |
| plot_seek | output | 1 | One-cycle plotter seek pulse |
| plot_done_async | input | 1 | Asynchronous plot-complete level |
| ext_flag_async | input | 1 | Asynchronous general flag level |
| host_flag_plot | output | 1 | Stretched flag from plot-complete |
| host_flag_ext | output | 1 | Stretched flag from the external flag |

## Verification
Three DAC values are written: the most positive, the most negative and minus one. Together they separate a correct XOR recoding from a plain sign flip, a full inversion or no recoding. A Z write with an irregular bit pattern shows that only the DAC slots recode. The bench sends an X-only write, then a Y write, a reserved-address write and an input command, counting `plot_seek` and `in_cmd_valid` pulses after each. This tells a seek tied to Y apart from one tied to any write, and a discarded write apart from one aliased onto a real slot. Each flag input is pulsed, and the other is held high, to tell edge detection apart from level following and to measure the stretch length.

// File: rtl/outreg_pkg.sv
package outreg_pkg;
  localparam int WORD_W = 16;
  localparam int DATA_W = 12;
  localparam int ADDR_W = 3;
  localparam int DIR_BIT = WORD_W - 1;

  typedef struct packed {
    logic              to_input;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

  // two's complement -> inverted offset binary: flip every bit but the sign
  function automatic logic [DATA_W-1:0] tc_to_iob(input logic [DATA_W-1:0] d);
    return d ^ {1'b0, {(DATA_W-1){1'b1}}};
  endfunction

  function automatic logic [DATA_W-1:0] iob_midscale();
    return tc_to_iob('0);
  endfunction
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import outreg_pkg::*;
#(
  parameter int Y_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [WORD_W-1:0] word,
  output cmd_t              cmd,
  output logic              out_wr,
  output logic              in_cmd_valid,
  output logic [ADDR_W-1:0] in_cmd_chan,
  output logic              plot_seek
);
  logic y_wr_q;

  always_comb begin
    cmd.to_input = word[DIR_BIT];
    cmd.addr     = word[DIR_BIT-1 -: ADDR_W];
    cmd.data     = word[DATA_W-1:0];
    out_wr       = accept && !cmd.to_input;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cmd_valid <= 1'b0;
      in_cmd_chan  <= '0;
      y_wr_q       <= 1'b0;
      plot_seek    <= 1'b0;
    end else begin
      in_cmd_valid <= accept && cmd.to_input;
      if (accept && cmd.to_input) in_cmd_chan <= cmd.addr;
      y_wr_q       <= out_wr && (cmd.addr == ADDR_W'(Y_ADDR));
      plot_seek    <= y_wr_q;
    end
  end
endmodule

// File: rtl/out_slot.sv
module out_slot
  import outreg_pkg::*;
#(
  parameter int ADDR   = 0,
  parameter bit RECODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  cmd_t              cmd,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] next_val;
  logic [DATA_W-1:0] rst_val;

  generate
    if (RECODE) begin : g_dac
      assign next_val = tc_to_iob(cmd.data);
      assign rst_val  = iob_midscale();
    end else begin : g_raw
      assign next_val = cmd.data;
      assign rst_val  = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)                                       q <= rst_val;
    else if (wr && cmd.addr == ADDR_W'(ADDR))         q <= next_val;
  end
endmodule

// File: rtl/flag_stretch.sv
module flag_stretch #(
  parameter int SYNC_STAGES = 2,
  parameter int LEN         = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic flag
);
  localparam int CW = $clog2(LEN + 1);

  logic [SYNC_STAGES-1:0] sync;
  logic                   last;
  logic [CW-1:0]          cnt;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) sync[i] <= 1'b0;
        else if (i == 0) sync[i] <= async_in;
        else sync[i] <= sync[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last <= 1'b0;
      cnt  <= '0;
    end else begin
      last <= sync[SYNC_STAGES-1];
      if (sync[SYNC_STAGES-1] && !last) cnt <= CW'(LEN);
      else if (cnt != '0)               cnt <= cnt - 1'b1;
    end
  end

  assign flag = (cnt != '0);
endmodule

// File: rtl/outreg_bank.sv
module outreg_bank
  import outreg_pkg::*;
#(
  parameter int X_ADDR      = 0,
  parameter int Y_ADDR      = 1,
  parameter int Z_ADDR      = 2,
  parameter int FLAG_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [WORD_W-1:0] cmd_word,
  output logic              in_cmd_valid,
  output logic [ADDR_W-1:0] in_cmd_chan,
  output logic [DATA_W-1:0] dac_x,
  output logic [DATA_W-1:0] dac_y,
  output logic [DATA_W-1:0] z_out,
  output logic              plot_seek,
  input  logic              plot_done_async,
  input  logic              ext_flag_async,
  output logic              host_flag_plot,
  output logic              host_flag_ext
);
  cmd_t cmd;
  logic out_wr;
  logic accept;

  assign cmd_ready = 1'b1;
  assign accept    = cmd_valid && cmd_ready;

  cmd_decode #(.Y_ADDR(Y_ADDR)) u_dec (
    .clk(clk), .rst_n(rst_n), .accept(accept), .word(cmd_word),
    .cmd(cmd), .out_wr(out_wr), .in_cmd_valid(in_cmd_valid),
    .in_cmd_chan(in_cmd_chan), .plot_seek(plot_seek)
  );

  out_slot #(.ADDR(X_ADDR), .RECODE(1'b1)) u_x (
    .clk(clk), .rst_n(rst_n), .wr(out_wr), .cmd(cmd), .q(dac_x));
  out_slot #(.ADDR(Y_ADDR), .RECODE(1'b1)) u_y (
    .clk(clk), .rst_n(rst_n), .wr(out_wr), .cmd(cmd), .q(dac_y));
  out_slot #(.ADDR(Z_ADDR), .RECODE(1'b0)) u_z (
    .clk(clk), .rst_n(rst_n), .wr(out_wr), .cmd(cmd), .q(z_out));

  logic [1:0] async_v;
  logic [1:0] flag_v;
  assign async_v = {ext_flag_async, plot_done_async};

  generate
    for (genvar f = 0; f < 2; f++) begin : g_flag
      flag_stretch #(.SYNC_STAGES(2), .LEN(FLAG_CYCLES)) u_fs (
        .clk(clk), .rst_n(rst_n), .async_in(async_v[f]), .flag(flag_v[f]));
    end
  endgenerate

  assign host_flag_plot = flag_v[0];
  assign host_flag_ext  = flag_v[1];
endmodule

// File: rtl/outreg_bank_chk.sv
module outreg_bank_chk
  import outreg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [WORD_W-1:0] cmd_word,
  input logic              in_cmd_valid,
  input logic [DATA_W-1:0] dac_x,
  input logic [DATA_W-1:0] dac_y,
  input logic [DATA_W-1:0] z_out,
  input logic              plot_seek,
  input logic              host_flag_plot,
  input logic              host_flag_ext
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  p_in_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_cmd_valid |-> $past(acc && cmd_word[15]));

  p_hold_x_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(dac_x) && $stable(dac_y) && $stable(z_out));

  p_input_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_word[15]) |=> $stable(dac_x) && $stable(dac_y) && $stable(z_out));

  p_seek_after_y_r5: assert property (@(posedge clk) disable iff (!rst_n)
    plot_seek |-> $past(acc && !cmd_word[15] && cmd_word[14:12] == 3'd1, 2));

  p_flag_plot_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_flag_plot) |=> host_flag_plot);

  p_flag_ext_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_flag_ext) |=> host_flag_ext);
endmodule

bind outreg_bank outreg_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_word(cmd_word), .in_cmd_valid(in_cmd_valid), .dac_x(dac_x),
  .dac_y(dac_y), .z_out(z_out), .plot_seek(plot_seek),
  .host_flag_plot(host_flag_plot), .host_flag_ext(host_flag_ext)
);

// File: tb/tb_outreg_bank.sv
module tb_outreg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_word = '0;
  logic        in_cmd_valid;
  logic [2:0]  in_cmd_chan;
  logic [11:0] dac_x, dac_y, z_out;
  logic        plot_seek;
  logic        plot_done_async = 1'b0;
  logic        ext_flag_async = 1'b0;
  logic        host_flag_plot, host_flag_ext;

  int checks = 0;
  int errors = 0;
  int seek_cnt, incmd_cnt;
  logic [2:0] chan_seen;

  always #10 clk = ~clk;

  outreg_bank dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .in_cmd_valid(in_cmd_valid), .in_cmd_chan(in_cmd_chan),
    .dac_x(dac_x), .dac_y(dac_y), .z_out(z_out), .plot_seek(plot_seek),
    .plot_done_async(plot_done_async), .ext_flag_async(ext_flag_async),
    .host_flag_plot(host_flag_plot), .host_flag_ext(host_flag_ext)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue one command; count pulses over the following cycles.
  task automatic send(input logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = 16'hFFFF;
    seek_cnt = 0; incmd_cnt = 0; chan_seen = '0;
    if (in_cmd_valid) begin incmd_cnt++; chan_seen = in_cmd_chan; end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (plot_seek) seek_cnt++;
      if (in_cmd_valid) begin incmd_cnt++; chan_seen = in_cmd_chan; end
    end
  endtask

  task automatic t_reset;
    check("R8 dac_x", dac_x, 12'h7FF);
    check("R8 dac_y", dac_y, 12'h7FF);
    check("R8 z_out", z_out, 12'h000);
    check("R8 pulses", {plot_seek, in_cmd_valid, host_flag_plot, host_flag_ext}, 0);
  endtask

  task automatic t_x_recode;
    send(16'h07FF); check("R2 x max pos", dac_x, 12'h000);
    check("R5 no seek on X", seek_cnt, 0);
    send(16'h0800); check("R2 x min neg", dac_x, 12'hFFF);
    send(16'h0FFF); check("R2 x minus one", dac_x, 12'h800);
  endtask

  task automatic t_y_seek;
    send(16'h1123); check("R3 y recode", dac_y, 12'h123 ^ 12'h7FF);
    check("R5 one seek", seek_cnt, 1);
    check("R3 x untouched", dac_x, 12'h800);
  endtask

  task automatic t_z;
    send(16'h2A5C); check("R4 z raw", z_out, 12'hA5C);
    check("R4 dac_y untouched", dac_y, 12'h123 ^ 12'h7FF);
  endtask

  task automatic t_reserved;
    for (int a = 3; a < 8; a++) begin
      send({1'b0, 3'(a), 12'h3C3});
      check("R6 regs kept", {dac_x, dac_y, z_out}, {12'h800, 12'h123 ^ 12'h7FF, 12'hA5C});
      check("R6 no pulses", seek_cnt + incmd_cnt, 0);
    end
  endtask

  task automatic t_input_cmd;
    send(16'hD456);
    check("R1 one in pulse", incmd_cnt, 1);
    check("R1 channel", chan_seen, 3'd5);
    check("R1 regs kept", {dac_x, dac_y, z_out}, {12'h800, 12'h123 ^ 12'h7FF, 12'hA5C});
    check("R1 no seek", seek_cnt, 0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_word = 16'h1000;
    seek_cnt = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (plot_seek || in_cmd_valid) seek_cnt++; end
    check("R7 idle regs", {dac_x, dac_y, z_out}, {12'h800, 12'h123 ^ 12'h7FF, 12'hA5C});
    check("R7 idle pulses", seek_cnt, 0);
  endtask

  task automatic t_flags;
    int hp, he;
    @(negedge clk); plot_done_async = 1'b1;
    hp = 0; he = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (host_flag_plot) hp++; if (host_flag_ext) he++; end
    check("R9 plot flag length", hp, 4);
    check("R10 ext quiet", he, 0);
    plot_done_async = 1'b0;
    ext_flag_async = 1'b1;
    hp = 0; he = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (host_flag_plot) hp++; if (host_flag_ext) he++; end
    check("R10 ext flag length", he, 4);
    check("R9 plot quiet", hp, 0);
    he = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (host_flag_ext) he++; end
    check("R10 level no repeat", he, 0);
    ext_flag_async = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_x_recode();
    t_y_seek();
    t_z();
    t_reserved();
    t_input_cmd();
    t_idle();
    t_flags();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule